// File: doc/BRIEF.md
# Trigger Combiner and Trace Capture Controller

This block decides when a capture trigger happens and records a trace of samples around it. Each cycle, a vector of per-probe match flags from external comparators is folded into a single trigger condition. A run-time mode input picks the fold: every flag must be set, or any one flag is enough. A rising edge on a cross-trigger input from a neighbouring analyzer also starts a capture. The block answers that edge with a one-cycle acknowledge. When a trigger occurs, the block raises a cross-trigger output and holds it until a downstream analyzer acknowledges it. This lets several analyzers be chained.

Samples come in as a valid/ready stream. The block never stalls the source: `smp_ready` reports whether a sample presented now can be stored, and a sample offered while it is low is dropped. A storage qualifier can restrict writing to the samples whose qualifier flag is set. Stored samples go into a circular memory of `DEPTH` entries, where `DEPTH` is a power of two from 1024 to 131072. The trigger may occur before the memory has filled. After the trigger, writing continues until the memory holds a full `DEPTH` samples since arming and at least `POST_LEN` samples counted from the trigger sample. The trace is then frozen, `done` rises, and the memory can be read at leisure. The address of the trigger sample is kept so a reader can locate it in the circular trace. Everything runs on the one clock of the observed logic.

Top module: `trace_capture_top`

## Requirements
- R1: After reset, `done`, `cross_out`, `cross_in_ack` and `smp_ready` are all 0, and the controller is idle (not capturing).
- R2: With `or_mode` = 0 (AND combining), a comparator trigger happens only in a cycle with `smp_valid` = 1 and every bit of `match` = 1. A vector with any bit at 0 does not trigger.
- R3: With `or_mode` = 1 (OR combining), a comparator trigger happens in a cycle with `smp_valid` = 1 and at least one `match` bit = 1. An all-zero vector does not trigger.
- R4: With `qual_en` = 1, only samples accepted with `qual` = 1 are written. Written samples occupy consecutive addresses starting at 0 after arming. With `qual_en` = 0, every accepted sample is written.
- R5: After a trigger, writing continues until `DEPTH` samples have been written since arming and `POST_LEN` samples have been written from the trigger sample on. `done` rises at the edge of the last write. While done, the memory contents no longer change.
- R6: `cross_out` rises at the clock edge that registers a trigger. It stays high while `cross_out_ack` is 0 and falls at the first edge that samples `cross_out_ack` = 1.
- R7: A rising edge on `cross_in` while armed acts as a trigger, ORed with the comparator condition. `cross_in_ack` is then high for exactly one cycle after that edge. A `cross_in` edge while not armed is ignored: it gives no acknowledge and no trigger.
- R8: `trig_addr` holds the write address that was current in the trigger cycle, which is the address of the trigger sample when it is stored.
- R9: `rd_data` returns the memory word at `rd_addr` one cycle after the address is presented.
- R10: `arm` is accepted when idle or done. It clears the write address, so the first stored sample lands at address 0. `arm` is ignored while armed or triggered.
- R11: `smp_ready` is 1 exactly while the controller is armed or triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the observed logic |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start-capture strobe |
| or_mode | input | 1 | 0: all flags must match; 1: any flag matches |
| match | input | N_PROBES | Per-probe comparator match flags |
| qual_en | input | 1 | Enables the storage qualifier |
| qual | input | 1 | Qualifier flag for the current sample |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | High when an offered sample can be stored |
| smp_data | input | WIDTH | Sample stream data |
| cross_in | input | 1 | Cross-trigger from another analyzer |
| cross_in_ack | output | 1 | One-cycle acknowledge of cross_in |
| cross_out | output | 1 | Trigger indication to other analyzers |
| cross_out_ack | input | 1 | Acknowledge that clears cross_out |
| rd_addr | input | AW | Trace read address |
| rd_data | output | WIDTH | Trace read data, one cycle latency |
| trig_addr | output | AW | Address of the trigger sample |
| done | output | 1 | Trace complete and frozen |

## Verification
The interesting collision is a comparator match and a rising cross-trigger edge landing in the same armed cycle. The bench provokes it by driving a full AND match together with the `cross_in` edge on a valid sample. It then judges that exactly one trigger results: a single acknowledge pulse, `cross_out` rising once, and `trig_addr` pointing at that sample. The second collision is arming in the same cycle as a write while already armed. There the bench requires that the write lands and the address is not reset.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/trc_combine.sv
module trc_combine #(
  parameter int N_PROBES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armed,
  input  logic                or_mode,
  input  logic [N_PROBES-1:0] match,
  input  logic                smp_valid,
  input  logic                cross_in,
  output logic                hit,
  output logic                cross_in_ack
);
  logic cross_q;
  logic cross_rise;
  logic all_m, any_m;

  // reduction built per flag so wide probe sets stay regular
  logic [N_PROBES:0] and_chain, or_chain;
  assign and_chain[0] = 1'b1;
  assign or_chain[0]  = 1'b0;
  for (genvar g = 0; g < N_PROBES; g++) begin : g_fold
    assign and_chain[g+1] = and_chain[g] & match[g];
    assign or_chain[g+1]  = or_chain[g]  | match[g];
  end
  assign all_m = and_chain[N_PROBES];
  assign any_m = or_chain[N_PROBES];

  assign cross_rise = cross_in && !cross_q;
  assign hit = armed && ((smp_valid && (or_mode ? any_m : all_m)) || cross_rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cross_q      <= 1'b0;
      cross_in_ack <= 1'b0;
    end else begin
      cross_q      <= cross_in;
      cross_in_ack <= armed && cross_rise;
    end
  end

  p_inack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cross_in_ack |=> !cross_in_ack);
  p_and_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!or_mode && !(&match) && !(cross_in && !cross_q)) |-> !hit);
  p_or_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (or_mode && (match == '0) && !(cross_in && !cross_q)) |-> !hit);
endmodule

// File: rtl/trc_store.sv
module trc_store #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] rd
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int POST_LEN = DEPTH / 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          hit,
  input  logic          smp_valid,
  input  logic          qual_en,
  input  logic          qual,
  input  logic          cross_out_ack,
  output logic          armed,
  output logic          capturing,
  output logic          we,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] trig_addr,
  output logic          done,
  output logic          cross_out
);
  localparam logic [AW:0] FULL  = (AW+1)'(DEPTH);
  localparam logic [AW:0] POSTL = (AW+1)'(POST_LEN);

  cap_state_e state_q, state_d;
  logic [AW:0] fill_q, fill_d, post_q, post_d;
  logic fire, finish, rearm;

  assign armed     = (state_q == ST_ARMED);
  assign capturing = (state_q == ST_ARMED) || (state_q == ST_TRIG);
  assign we        = capturing && smp_valid && (!qual_en || qual);
  assign fire      = armed && hit;
  assign rearm     = arm && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign done      = (state_q == ST_DONE);

  always_comb begin
    fill_d = fill_q;
    if (we && fill_q != FULL) fill_d = fill_q + 1'b1;
    post_d = post_q;
    if (fire) post_d = {{AW{1'b0}}, we};
    else if (state_q == ST_TRIG && we && post_q != POSTL) post_d = post_q + 1'b1;
    finish = (fill_d == FULL) && (post_d >= POSTL);
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rearm) state_d = ST_ARMED;
      ST_ARMED: if (fire) state_d = finish ? ST_DONE : ST_TRIG;
      ST_TRIG:  if (finish) state_d = ST_DONE;
      ST_DONE:  if (rearm) state_d = ST_ARMED;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_ptr    <= '0;
      fill_q    <= '0;
      post_q    <= '0;
      trig_addr <= '0;
      cross_out <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rearm) begin
        wr_ptr <= '0;
        fill_q <= '0;
        post_q <= '0;
      end else begin
        if (we) wr_ptr <= wr_ptr + 1'b1;
        fill_q <= fill_d;
        post_q <= post_d;
      end
      if (fire) trig_addr <= wr_ptr;
      if (fire) cross_out <= 1'b1;
      else if (cross_out_ack) cross_out <= 1'b0;
    end
  end

  p_tout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_out && !cross_out_ack) |=> cross_out);
  p_tout_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_out && cross_out_ack && !fire) |=> !cross_out);
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !arm) |=> (wr_ptr == $past(wr_ptr) + 1'b1));
  p_taddr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIG) |=> $stable(trig_addr));
  p_state_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, state_q == ST_TRIG, done}));
endmodule

// File: rtl/trace_capture_top.sv
module trace_capture_top #(
  parameter int N_PROBES = 4,
  parameter int WIDTH    = 16,
  parameter int DEPTH    = 1024,
  parameter int POST_LEN = DEPTH / 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                or_mode,
  input  logic [N_PROBES-1:0] match,
  input  logic                qual_en,
  input  logic                qual,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [WIDTH-1:0]    smp_data,
  input  logic                cross_in,
  output logic                cross_in_ack,
  output logic                cross_out,
  input  logic                cross_out_ack,
  input  logic [AW-1:0]       rd_addr,
  output logic [WIDTH-1:0]    rd_data,
  output logic [AW-1:0]       trig_addr,
  output logic                done
);
  logic armed, hit, we;
  logic [AW-1:0] wr_ptr;

  trc_combine #(.N_PROBES(N_PROBES)) u_comb (
    .clk(clk), .rst_n(rst_n), .armed(armed), .or_mode(or_mode),
    .match(match), .smp_valid(smp_valid), .cross_in(cross_in),
    .hit(hit), .cross_in_ack(cross_in_ack)
  );

  trc_ctrl #(.DEPTH(DEPTH), .POST_LEN(POST_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit),
    .smp_valid(smp_valid), .qual_en(qual_en), .qual(qual),
    .cross_out_ack(cross_out_ack), .armed(armed), .capturing(smp_ready),
    .we(we), .wr_ptr(wr_ptr), .trig_addr(trig_addr), .done(done),
    .cross_out(cross_out)
  );

  trc_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(we), .wa(wr_ptr), .wd(smp_data),
    .ra(rd_addr), .rd(rd_data)
  );
endmodule

// File: tb/test_trace_capture_top.sv
module test_trace_capture_top;
  localparam int N = 4;
  localparam int W = 16;
  localparam int D = 1024;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 0, or_mode = 0, qual_en = 0, qual = 0, smp_valid = 0;
  logic cross_in = 0, cross_out_ack = 0;
  logic [N-1:0] match = '0;
  logic [W-1:0] smp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic smp_ready, cross_in_ack, cross_out, done;
  logic [W-1:0] rd_data;
  logic [AW-1:0] trig_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trace_capture_top #(.N_PROBES(N), .WIDTH(W), .DEPTH(D)) i_trace_capture_top (
    .clk(clk), .rst_n(rst_n), .arm(arm), .or_mode(or_mode), .match(match),
    .qual_en(qual_en), .qual(qual), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cross_in(cross_in), .cross_in_ack(cross_in_ack),
    .cross_out(cross_out), .cross_out_ack(cross_out_ack), .rd_addr(rd_addr),
    .rd_data(rd_data), .trig_addr(trig_addr), .done(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    arm = 0; smp_valid = 0; match = '0; qual = 0; cross_in = 0; cross_out_ack = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    qual_en = 0; or_mode = 0;
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
  endtask

  task automatic do_arm();
    arm = 1; cyc(); arm = 0;
  endtask

  task automatic put(input logic [W-1:0] d, input logic [N-1:0] m);
    smp_valid = 1; smp_data = d; match = m; cyc(); smp_valid = 0; match = '0;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [W-1:0] exp);
    rd_addr = AW'(a); cyc(); chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done", done, 0);
    chk("R1 cross_out", cross_out, 0);
    chk("R1 cross_in_ack", cross_in_ack, 0);
    chk("R1 smp_ready", smp_ready, 0);
  endtask

  task automatic t_and_full();
    int n;
    do_reset();
    or_mode = 0;
    do_arm();
    chk("R11 ready when armed", smp_ready, 1);
    for (int i = 0; i < 5; i++) begin
      put(16'h1000 + W'(i), 4'b0111);
      chk("R2 partial match no trigger", cross_out, 0);
    end
    put(16'h1005, 4'b1111);
    chk("R2 full match triggers", cross_out, 1);
    chk("R8 trig_addr", trig_addr, 5);
    n = 6;
    for (int i = 0; i < 3; i++) begin
      put(16'h1000 + W'(n), '0); n++;
      chk("R6 cross_out held without ack", cross_out, 1);
    end
    cross_out_ack = 1; put(16'h1000 + W'(n), '0); n++; cross_out_ack = 0;
    chk("R6 cross_out drops on ack", cross_out, 0);
    while (n < D - 1) begin put(16'h1000 + W'(n), 4'b1111); n++; end
    chk("R5 not done before full", done, 0);
    chk("R6 no retrigger while triggered", cross_out, 0);
    put(16'h1000 + W'(n), '0);
    chk("R5 done at last write", done, 1);
    chk("R11 ready low when done", smp_ready, 0);
    for (int i = 0; i < 3; i++) put(16'hFFFF, 4'b1111);
    rd_chk("R5 R9 addr0 frozen", 0, 16'h1000);
    rd_chk("R9 trigger sample", 5, 16'h1005);
    rd_chk("R9 last sample", D - 1, 16'h1000 + W'(D - 1));
    do_arm();
    chk("R10 rearm from done", done, 0);
    chk("R10 ready after rearm", smp_ready, 1);
    put(16'h5555, '0);
    rd_chk("R10 pointer cleared", 0, 16'h5555);
  endtask

  task automatic t_or();
    do_reset();
    or_mode = 1;
    do_arm();
    for (int i = 0; i < 3; i++) begin
      put(16'h2000 + W'(i), '0);
      chk("R3 no flag no trigger", cross_out, 0);
    end
    put(16'h2003, 4'b0100);
    chk("R3 single flag triggers", cross_out, 1);
    chk("R8 trig_addr or", trig_addr, 3);
  endtask

  task automatic t_qual();
    do_reset();
    qual_en = 1;
    do_arm();
    for (int i = 0; i < 8; i++) begin
      qual = (i % 2 == 0);
      put(16'h0100 + W'(i), '0);
    end
    qual = 0;
    for (int i = 0; i < 4; i++) rd_chk("R4 qualified sample", i, 16'h0100 + W'(2 * i));
  endtask

  task automatic t_cross_in();
    do_reset();
    cross_in = 1; cyc();
    chk("R7 idle edge no ack", cross_in_ack, 0);
    chk("R7 idle edge no trigger", cross_out, 0);
    cross_in = 0;
    do_arm();
    cross_in = 1; cyc();
    chk("R7 ack pulse", cross_in_ack, 1);
    chk("R7 cross trigger", cross_out, 1);
    chk("R8 trig_addr empty", trig_addr, 0);
    cyc();
    chk("R7 ack one cycle", cross_in_ack, 0);
    cross_in = 0;
  endtask

  task automatic t_collide();
    do_reset();
    do_arm();
    put(16'h3000, '0); put(16'h3001, '0);
    cross_in = 1; put(16'h3002, 4'b1111);
    chk("R7 ack on collision", cross_in_ack, 1);
    chk("R6 trigger on collision", cross_out, 1);
    chk("R8 trig_addr collision", trig_addr, 2);
    cross_out_ack = 1; cyc(); cross_out_ack = 0;
    chk("R7 single ack", cross_in_ack, 0);
    chk("R6 single trigger", cross_out, 0);
    cross_in = 0;
    rd_chk("R9 collision sample", 2, 16'h3002);
  endtask

  task automatic t_arm_ignored();
    do_reset();
    do_arm();
    for (int i = 0; i < 5; i++) put(16'h4000 + W'(i), '0);
    arm = 1; put(16'h4005, '0); arm = 0;
    put(16'h4006, 4'b1111);
    chk("R10 arm ignored while armed", trig_addr, 6);
    rd_chk("R10 write kept", 5, 16'h4005);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_and_full();
    t_or();
    t_qual();
    t_cross_in();
    t_collide();
    t_arm_ignored();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule